// File: doc/BRIEF.md
# Multi-Hart Machine Timer Unit

This block is the shared wall-clock timer for a small multi-core cluster. It keeps one 64-bit time count that advances by one on every clock cycle in which the tick-enable input is high. For each hart it keeps a 64-bit compare value and drives a level-sensitive timer interrupt line. The line for a hart is high whenever the time count has reached or passed that hart's compare value.

Software reaches the unit over a simple 32-bit register port: one valid strobe per access, a write flag, a byte address, write data and registered read data. Every 64-bit quantity appears as two 32-bit words. The lower address holds the less significant word. Compare slots are 8 bytes apart, starting at a parameterised base. The time count sits alone at a second parameterised base. Both bases are 8-byte aligned.

The count itself cannot be written from the bus. A read of the low word followed by the high word is not atomic, so software must allow for a carry between the two reads.

Top module: `mtu_timer_top`

## Requirements
- R1: After reset every compare value is zero, the time count equals the parameter TIME_INIT, every interrupt line is high (compare 0 is at or below any time), and read data is zero.
- R2: On each rising clock edge with tick_en high the time count increases by exactly one, with carry from bit 31 into bit 32. With tick_en low it holds.
- R3: A read at TIME_BASE returns time bits 31:0 and a read at TIME_BASE+4 returns bits 63:32. The value is the count sampled at the accepting edge, and it is visible on bus_rdata from the cycle after that edge.
- R4: Bus writes to either time word leave the count unchanged.
- R5: Hart i's compare value is reached at CMP_BASE+8*i. Byte offset 0 in the slot holds bits 31:0 and offset 4 holds bits 63:32. Reads return the stored word one cycle after the access.
- R6: Writing one word of a compare value leaves the other word unchanged. The merged value is used from the next cycle on.
- R7: Each interrupt line is a register equal to (compare <= time). The comparison is evaluated on the values that take effect at each edge. After a compare write, the line rises immediately if the new value is at or below time and falls otherwise, visible in the cycle after the write.
- R8: A line that is low rises in the cycle after the time count reaches the compare value through ticking, and it stays high while time stays at or above that value.
- R9: Reads of unmapped addresses, of slot offsets other than 0 and 4, of slots beyond the last hart, or of odd offsets near the time base return zero. Writes to any of them change no compare value and no interrupt line.
- R10: A write to one hart's compare value does not change any other hart's compare value or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the time count this cycle |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench starts the count just below 2^32 so that a few ticks carry into the high word. A counter with a broken carry would read back a high word of zero. It drives compare values exactly equal to, one above and one below the current time. A comparison using strict less-than, or one updated only on ticks, would leave a line wrong right after a write. It also probes slot offsets 1 and 2, a slot past the last hart, an odd time offset and a far unmapped address, with both reads and writes. A sloppy decoder would alias these onto real registers, returning nonzero data or corrupting a compare value.

// File: rtl/mtu_pkg.sv
// Package: shared widths and the decoded access type for the machine timer unit.
// Assumes 32-bit bus words and 64-bit time/compare quantities.
package mtu_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 64;

    // One-hot-or-none description of what a bus address selects.
    typedef struct packed {
        logic time_lo;   // time bits 31:0
        logic time_hi;   // time bits 63:32
        logic cmp_hit;   // valid word inside a compare slot
        logic cmp_hi;    // 1 = upper word of the selected compare slot
    } mtu_dec_t;
endpackage

// File: rtl/mtu_time_counter.sv
// Module: free-running 64-bit time count.
// Advances by one per enabled cycle; exposes both the current and the
// next-cycle value so that consumers can register results in step with it.
// Assumes a synchronous active-low reset; no write path exists by design.
module mtu_time_counter #(
    parameter logic [63:0] TIME_INIT = 64'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    output logic [63:0] time_q,
    output logic [63:0] time_d
);
    // Next value: increment on tick, else hold.
    always_comb begin
        time_d = tick_en ? time_q + 64'd1 : time_q;
    end

    // State register for the count.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= TIME_INIT;
        else        time_q <= time_d;
    end

    // R2: each enabled cycle adds exactly one.
    p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_en)) |-> (time_q == $past(time_q) + 64'd1));

    // R4: without a tick nothing, including bus writes, moves the count.
    p_time_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en)) |-> $stable(time_q));
endmodule

// File: rtl/mtu_addr_decode.sv
// Module: byte-address decoder for the timer register window.
// Produces the target kind and the local hart index of a compare slot.
// Assumes CMP_BASE and TIME_BASE are 8-byte aligned and the regions do not
// overlap; only word offsets 0 and 4 within a slot are valid.
module mtu_addr_decode
    import mtu_pkg::*;
#(
    parameter int                NUM_HARTS = 4,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE = '0,
    localparam int               HIDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output mtu_dec_t          dec,
    output logic [HIDX_W-1:0] hart_idx
);
    localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(NUM_HARTS * 8);
    localparam logic [ADDR_W-1:0] TIME_HI_A = TIME_BASE + ADDR_W'(4);

    logic [ADDR_W-1:0] off;

    // Offset from the compare base; wraps high for addresses below it.
    always_comb begin
        off = addr - CMP_BASE;
    end

    // Classify the address into one target or none.
    always_comb begin
        dec          = '0;
        dec.time_lo  = (addr == TIME_BASE);
        dec.time_hi  = (addr == TIME_HI_A);
        dec.cmp_hit  = (off < SPAN) && (off[1:0] == 2'b00);
        dec.cmp_hi   = off[2];
        hart_idx     = off[3 +: HIDX_W];
    end

    // R9: an address selects at most one target.
    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.time_lo, dec.time_hi, dec.cmp_hit}));
endmodule

// File: rtl/mtu_hart_slot.sv
// Module: one hart's 64-bit compare value and its registered interrupt level.
// Word writes merge into the stored value; the interrupt is evaluated on the
// values that take effect at each edge, so it tracks (compare <= time) with
// no extra cycle. Assumes the time inputs come from mtu_time_counter.
module mtu_hart_slot #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  time_q,
    input  logic [CNT_W-1:0]  time_d,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              irq_q
);
    logic [CNT_W-1:0] cmp_d;

    // Merge a word write into the held compare value.
    always_comb begin
        cmp_d = cmp_q;
        if (wr_lo) cmp_d[WORD_W-1:0]     = wdata;
        if (wr_hi) cmp_d[CNT_W-1:WORD_W] = wdata;
    end

    // Compare register and interrupt level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            irq_q <= 1'b1;
        end else begin
            cmp_q <= cmp_d;
            irq_q <= (cmp_d <= time_d);
        end
    end

    // R6: a low-word write keeps the upper word.
    p_keep_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_lo) && !$past(wr_hi))
            |-> (cmp_q[CNT_W-1:WORD_W] == $past(cmp_q[CNT_W-1:WORD_W])));

    // R6: an upper-word write keeps the low word.
    p_keep_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hi) && !$past(wr_lo))
            |-> (cmp_q[WORD_W-1:0] == $past(cmp_q[WORD_W-1:0])));

    // R7: the level always agrees with the live comparison.
    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_q == (cmp_q <= time_q)));

    // R10: without a write to this slot its value holds.
    p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_lo) && !$past(wr_hi)) |-> $stable(cmp_q));
endmodule

// File: rtl/mtu_timer_top.sv
// Module: multi-hart machine timer unit top.
// Ties the time counter, the address decoder and one compare slot per hart
// to a 32-bit register port with registered read data. Assumes one access
// per cycle on bus_valid; reads of anything not mapped return zero.
module mtu_timer_top
    import mtu_pkg::*;
#(
    parameter int                NUM_HARTS = 4,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h4000,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'hBFF8,
    parameter logic [63:0]       TIME_INIT = 64'd0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] timer_irq
);
    localparam int HIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    logic [CNT_W-1:0]  time_q;
    logic [CNT_W-1:0]  time_d;
    mtu_dec_t          dec;
    logic [HIDX_W-1:0] hart_idx;
    logic [CNT_W-1:0]  cmp_val [NUM_HARTS];
    logic              wr_cmp;
    logic              hit_any;
    logic [WORD_W-1:0] rd_mux;

    mtu_time_counter #(
        .TIME_INIT (TIME_INIT)
    ) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .time_q  (time_q),
        .time_d  (time_d)
    );

    mtu_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .dec      (dec),
        .hart_idx (hart_idx)
    );

    // Qualify compare writes; time writes have no path and are dropped.
    always_comb begin
        wr_cmp  = bus_valid && bus_write && dec.cmp_hit;
        hit_any = dec.time_lo || dec.time_hi || dec.cmp_hit;
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic sel;
        // Steer the write to this hart when the index matches.
        always_comb begin
            sel = wr_cmp && (hart_idx == HIDX_W'(h));
        end

        mtu_hart_slot #(
            .WORD_W (WORD_W),
            .CNT_W  (CNT_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (sel && !dec.cmp_hi),
            .wr_hi  (sel && dec.cmp_hi),
            .wdata  (bus_wdata),
            .time_q (time_q),
            .time_d (time_d),
            .cmp_q  (cmp_val[h]),
            .irq_q  (timer_irq[h])
        );
    end

    // Select the read word for the addressed register, zero otherwise.
    always_comb begin
        rd_mux = '0;
        if (dec.time_lo)      rd_mux = time_q[WORD_W-1:0];
        else if (dec.time_hi) rd_mux = time_q[CNT_W-1:WORD_W];
        else if (dec.cmp_hit) begin
            rd_mux = dec.cmp_hi ? cmp_val[hart_idx][CNT_W-1:WORD_W]
                                : cmp_val[hart_idx][WORD_W-1:0];
        end
    end

    // Register the read data on each read access.
    always_ff @(posedge clk) begin
        if (!rst_n)                        bus_rdata <= '0;
        else if (bus_valid && !bus_write)  bus_rdata <= rd_mux;
    end

    // R9: a read of nothing mapped returns zero.
    p_bad_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_valid && !bus_write && !hit_any))
            |-> (bus_rdata == 32'd0));

    // R3: a read of the time low word returns the count seen at that edge.
    p_time_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_valid && !bus_write && dec.time_lo))
            |-> (bus_rdata == $past(time_q[WORD_W-1:0])));
endmodule

// File: tb/tb_mtu_timer_top.sv
module tb_mtu_timer_top;
    localparam int          NH   = 4;
    localparam int          AW   = 16;
    localparam logic [15:0] CB   = 16'h4000;
    localparam logic [15:0] TB   = 16'hBFF8;
    localparam logic [63:0] TINI = 64'h0000_0000_FFFF_FFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] timer_irq;

    mtu_timer_top #(
        .NUM_HARTS (NH), .ADDR_W (AW), .CMP_BASE (CB),
        .TIME_BASE (TB), .TIME_INIT (TINI)
    ) dut (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .timer_irq (timer_irq)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic        rd_fire = 1'b0;
    logic [63:0] model_time = TINI;

    // Independent time model from the requirements (R2).
    always @(posedge clk) begin
        if (!rst_n)       model_time <= TINI;
        else if (tick_en) model_time <= model_time + 64'd1;
        rd_fire <= bus_valid && !bus_write;
    end

    // Monitor: pop one expected item per completed read.
    always @(negedge clk) begin
        if (rd_fire) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %h", bus_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (bus_rdata < e.lo || bus_rdata > e.hi) begin
                    n_bad++;
                    $display("FAIL %s: read actual %h expected %h..%h", e.tag, bus_rdata, e.lo, e.hi);
                end
            end
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd_rng(input logic [15:0] a, input logic [31:0] lo,
                              input logic [31:0] hi, input string tag);
        exp_t e;
        @(negedge clk);
        e.lo = lo; e.hi = hi; e.tag = tag;
        sb.push_back(e);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [31:0] v, input string tag);
        bus_rd_rng(a, v, v, tag);
    endtask

    task automatic chk_irq(input logic [NH-1:0] exp, input string tag);
        n_cmp++;
        if (timer_irq !== exp) begin
            n_bad++;
            $display("FAIL %s: timer_irq actual %b expected %b", tag, timer_irq, exp);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

    // Driver: stimulus in requirement order.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_irq(4'b1111, "R1 reset irq");
        n_cmp++;
        if (bus_rdata !== 32'd0) begin
            n_bad++;
            $display("FAIL R1 reset rdata: actual %h expected 0", bus_rdata);
        end
        bus_rd(TB,           32'hFFFF_FFF0, "R1 R3 time lo at reset");
        bus_rd(TB + 16'd4,   32'h0,         "R1 R3 time hi at reset");
        bus_rd(CB,           32'h0,         "R1 R5 cmp0 lo at reset");
        bus_rd(CB + 16'd28,  32'h0,         "R1 R5 cmp3 hi at reset");

        // R4 time writes are dropped
        bus_wr(TB,         32'h1234_5678);
        bus_wr(TB + 16'd4, 32'hDEAD_BEEF);
        bus_rd(TB,         32'hFFFF_FFF0, "R4 time lo after write");
        bus_rd(TB + 16'd4, 32'h0,         "R4 time hi after write");

        // R7 R10 future compare on hart1 drops only its line
        bus_wr(CB + 16'd12, 32'h1);
        chk_irq(4'b1101, "R7 R10 hart1 future");
        bus_wr(CB + 16'd8, 32'h5);
        bus_rd(CB + 16'd12, 32'h1, "R6 cmp1 hi kept");
        bus_rd(CB + 16'd8,  32'h5, "R5 cmp1 lo");

        // R7 boundary: above, equal, above by one
        bus_wr(CB + 16'd16, 32'hFFFF_FFF5);
        chk_irq(4'b1001, "R7 hart2 above time");
        bus_wr(CB + 16'd16, 32'hFFFF_FFF0);
        chk_irq(4'b1101, "R7 hart2 equal time");
        bus_wr(CB + 16'd16, 32'hFFFF_FFF1);
        chk_irq(4'b1001, "R7 hart2 one above");

        // R8 reaching the compare by ticking
        ticks(1);
        chk_irq(4'b1101, "R8 hart2 reached");
        ticks(15);
        bus_rd(TB,         32'h0, "R2 carry lo");
        bus_rd(TB + 16'd4, 32'h1, "R2 carry hi");
        chk_irq(4'b1101, "R8 hart1 not yet");
        ticks(4);
        chk_irq(4'b1101, "R8 hart1 one short");
        ticks(1);
        chk_irq(4'b1111, "R8 hart1 reached");
        bus_rd(TB, 32'h5, "R2 count after ticks");

        // R9 invalid reads
        bus_rd(CB + 16'd9,  32'h0, "R9 slot offset 1");
        bus_rd(CB + 16'd10, 32'h0, "R9 slot offset 2");
        bus_rd(CB + 16'd32, 32'h0, "R9 slot past last hart");
        bus_rd(16'h1000,    32'h0, "R9 unmapped");
        bus_rd(TB + 16'd2,  32'h0, "R9 time odd offset");

        // R9 invalid writes
        bus_wr(CB + 16'd9,  32'hFFFF_FFFF);
        bus_wr(CB + 16'd32, 32'hFFFF_FFFF);
        bus_wr(16'h1000,    32'hFFFF_FFFF);
        chk_irq(4'b1111, "R9 bad writes irq");
        bus_rd(CB + 16'd8,  32'h5, "R9 cmp1 lo intact");
        bus_rd(CB + 16'd12, 32'h1, "R9 cmp1 hi intact");

        // R10 hart3 far future, then immediate raise by writing past value
        bus_wr(CB + 16'd28, 32'hFFFF_FFFF);
        chk_irq(4'b0111, "R10 hart3 only");
        bus_rd(CB + 16'd28, 32'hFFFF_FFFF, "R5 cmp3 hi");
        bus_rd(CB + 16'd16, 32'hFFFF_FFF1, "R10 cmp2 intact");
        bus_wr(CB + 16'd28, 32'h0);
        chk_irq(4'b1111, "R7 immediate raise");

        // R3 reads with the count running; allow one step of slack
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            bus_rd_rng(TB, model_time[31:0], model_time[31:0] + 32'd1, "R3 live time lo");
        end
        @(negedge clk);
        tick_en = 1'b0;
        chk_irq(4'b1111, "R8 stays high");

        repeat (4) @(negedge clk);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        finish_run();
    end
endmodule